// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block steps a 10-bit charge-redistribution converter through one conversion. A start pulse launches the sequence. For each bit, from the heaviest weight (512) down to weight 1, the block presents a trial code to the weighted capacitor array. The trial code holds every bit decided so far, a 1 in the bit under test, and zeros below it. After a programmable settle interval the block samples a single comparator bit and decides that bit.

When the summing node sits above the comparator trip point, the trial bit is rejected and cleared. Otherwise it is kept for the rest of the conversion. After the lightest bit is decided, the final code is loaded into the result register and a one-cycle done strobe is raised.

An abort input drops a conversion in progress and sends the sequencer back to idle. The result register keeps the last completed code. The analog array and comparator sit outside this block. In the bench they are replaced by a behavioural model that compares the trial code with a stored input level.

Top module: `sar_step_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, sample strobe, trial code and result are all 0.
- R2: A start accepted in idle makes busy 1 and sets the trial code to 512 (only bit 9 set) on the next edge.
- R3: The comparator input is 1 when the summing node is above the trip point. In that case the bit under test is cleared; otherwise it stays 1. The next trial sets the next lighter bit to 1. For any input level from 0 to 1023 the final code equals that level.
- R4: An input level at or above full scale (1023 or more) converts to 1023. An input level at or below zero converts to 0.
- R5: The settle input is captured when start is accepted. Each of the 10 steps lasts settle+1 clock cycles, and the trial code changes only at the end of a step.
- R6: Done is high for exactly one cycle. It rises 10*(settle+1) edges after the edge that accepted start. The result register changes only on that same edge.
- R7: Abort during a conversion makes busy 0 on the next edge, with no done and no change to the result. Abort together with start in idle starts nothing.
- R8: A start pulse during a conversion is ignored: the timing and the result of the running conversion are unchanged.
- R9: A start pulse after an abort begins a fresh conversion with full timing and a correct result.
- R10: The sample strobe is high for exactly one cycle at the end of each step, 10 times per completed conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion start request |
| abort_i | input | 1 | Cancels a running conversion |
| settle_i | input | 8 | Extra settle cycles per step, captured at start |
| cmp_above_i | input | 1 | Comparator: 1 when the summing node is above the trip point |
| trial_code_o | output | 10 | Code applied to the capacitor array |
| sample_o | output | 1 | High in the cycle the comparator is sampled |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 10 | Last completed conversion code |

## Verification
The hardest case to reach is a stray start arriving in the middle of a step, while the settle input is being changed at the same time. Only the completion time and the code show whether the running conversion was disturbed. The bench pulses start partway through a conversion and changes the settle value in the same cycle. It then checks that done still arrives at the edge predicted from the original settle value, and that the code matches the original input level. A second hard case, abort followed at once by a restart with a different input level, is driven back to back in one task.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_e;

  // Code after the step at bit position idx is decided.
  function automatic logic [15:0] sar_decide(input logic [15:0] code,
                                             input int idx,
                                             input logic reject);
    logic [15:0] m;
    m = 16'(1) << idx;
    return reject ? (code & ~m) : code;
  endfunction

endpackage

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (load) begin
      reload_q <= load_val;
      cnt_q    <= load_val;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= reload_q;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/sar_bit_index.sv
module sar_bit_index #(
  parameter int WIDTH = 10,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             is_last
);
  always_ff @(posedge clk) begin
    if (!rst_n)                idx <= '0;
    else if (load)             idx <= IDX_W'(WIDTH - 1);
    else if (step && !is_last) idx <= idx - 1'b1;
  end

  assign is_last = (idx == '0);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int WIDTH = 10,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic             step,
  input  logic [IDX_W-1:0] idx,
  input  logic             reject,
  output logic [WIDTH-1:0] code
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)     code[i] <= 1'b0;
      else if (clear) code[i] <= 1'b0;
      else if (load)  code[i] <= (i == WIDTH - 1);
      else if (step) begin
        if (int'(idx) == i)          code[i] <= !reject;
        else if (int'(idx) == i + 1) code[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_step_sequencer.sv
module sar_step_sequencer
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 10,
  parameter int CNT_W = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] settle_i,
  input  logic             cmp_above_i,
  output logic [WIDTH-1:0] trial_code_o,
  output logic             sample_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  seq_state_e       state_q;
  logic             accept_start;
  logic             abort_hit;
  logic             step_end;
  logic             last_step;
  logic             timer_exp;
  logic [IDX_W-1:0] bit_idx;
  logic             bit_last;
  logic [WIDTH-1:0] final_code;

  assign accept_start = (state_q == SEQ_IDLE) && start_i && !abort_i;
  assign abort_hit    = (state_q == SEQ_CONV) && abort_i;
  assign step_end     = (state_q == SEQ_CONV) && !abort_i && timer_exp;
  assign last_step    = step_end && bit_last;
  assign final_code   = WIDTH'(sar_decide(16'(trial_code_o), int'(bit_idx), cmp_above_i));

  sar_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept_start), .load_val(settle_i),
    .run(state_q == SEQ_CONV), .expired(timer_exp)
  );

  sar_bit_index #(.WIDTH(WIDTH)) u_index (
    .clk(clk), .rst_n(rst_n), .load(accept_start), .step(step_end),
    .idx(bit_idx), .is_last(bit_last)
  );

  sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
    .clk(clk), .rst_n(rst_n), .clear(abort_hit || last_step),
    .load(accept_start), .step(step_end), .idx(bit_idx),
    .reject(cmp_above_i), .code(trial_code_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= last_step;
      if (last_step) result_o <= final_code;
      case (state_q)
        SEQ_IDLE: if (accept_start) state_q <= SEQ_CONV;
        SEQ_CONV: if (abort_hit || last_step) state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q == SEQ_CONV);
  assign sample_o = step_end;
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
  parameter int WIDTH = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             abort_i,
  input logic [WIDTH-1:0] trial_code_o,
  input logic             sample_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] result_o,
  input logic             accept_start,
  input logic             step_end
);
  localparam int SC_W = $clog2(WIDTH + 1) + 1;
  logic [SC_W-1:0] steps_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            steps_q <= '0;
    else if (accept_start) steps_q <= '0;
    else if (step_end)     steps_q <= steps_q + 1'b1;
  end

  assert_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start |=> busy_o && trial_code_o == (WIDTH'(1) << (WIDTH - 1)));

  assert_trial_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !sample_o && !abort_i) |=> $stable(trial_code_o));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_result_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && abort_i) |=> !busy_o && !done_o);

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !abort_i && !sample_o) |=> busy_o);

  assert_step_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> steps_q == SC_W'(WIDTH));

  assert_strobe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> busy_o);
endmodule

bind sar_step_sequencer sar_seq_checker #(.WIDTH(WIDTH)) u_seq_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
  .trial_code_o(trial_code_o), .sample_o(sample_o), .busy_o(busy_o),
  .done_o(done_o), .result_o(result_o), .accept_start(accept_start),
  .step_end(step_end)
);

// File: tb/sar_step_sequencer_bench.sv
module sar_step_sequencer_bench;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         abort_i = 1'b0;
  logic [7:0]   settle_i = '0;
  logic         cmp_above_i;
  logic [W-1:0] trial_code_o;
  logic         sample_o, busy_o, done_o;
  logic [W-1:0] result_o;

  int vin = 0;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  // Behavioural array + comparator: node above trip when trial exceeds input.
  always_comb cmp_above_i = (int'(trial_code_o) > vin);

  sar_step_sequencer u_sar_step_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .settle_i(settle_i), .cmp_above_i(cmp_above_i), .trial_code_o(trial_code_o),
    .sample_o(sample_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_code(input int v);
    if (v >= (1 << W) - 1) return (1 << W) - 1;
    if (v <= 0) return 0;
    return v;
  endfunction

  // Starts a conversion and checks first trial, timing, strobes, result, pulse.
  task automatic run_conv(input int v, input int s);
    int n, strobes, prev_res;
    vin = v;
    settle_i = 8'(s);
    prev_res = int'(result_o);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 1;
    strobes = 0;
    check(busy_o && trial_code_o == 10'd512, "R2", int'(trial_code_o), 512);
    while (!done_o && n < 5000) begin
      if (sample_o) strobes++;
      if (int'(result_o) != prev_res) check(0, "R6 early result", int'(result_o), prev_res);
      @(negedge clk);
      n++;
    end
    check(n == W * (s + 1) + 1, "R5/R6 latency", n, W * (s + 1) + 1);
    check(strobes == W, "R10 strobes", strobes, W);
    check(int'(result_o) == expect_code(v), "R3/R4 code", int'(result_o), expect_code(v));
    @(negedge clk);
    check(!done_o && !busy_o, "R6 one-cycle done", int'(done_o), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !sample_o, "R1 flags", int'(busy_o), 0);
    check(trial_code_o == '0 && result_o == '0, "R1 codes", int'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && result_o == '0, "R1 after release", int'(busy_o), 0);
  endtask

  task automatic t_codes;
    run_conv(0, 0);
    run_conv(1023, 0);
    run_conv(512, 1);
    run_conv(511, 2);
    run_conv(341, 3);
    run_conv(682, 0);
    run_conv(1, 5);
  endtask

  task automatic t_range_limits;
    run_conv(5000, 1);   // R4 above full scale
    run_conv(-40, 1);    // R4 below zero
  endtask

  task automatic t_abort;
    int prev;
    run_conv(300, 0);
    prev = int'(result_o);
    vin = 900; settle_i = 8'd2; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (12) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    check(!busy_o && !done_o, "R7 abort to idle", int'(busy_o), 0);
    for (int k = 0; k < 60; k++) begin
      if (done_o || busy_o) check(0, "R7 no done after abort", int'(done_o), 0);
      @(negedge clk);
    end
    check(int'(result_o) == prev, "R7 result kept", int'(result_o), prev);
    abort_i = 1'b1; start_i = 1'b1;
    @(negedge clk); abort_i = 1'b0; start_i = 1'b0;
    check(!busy_o, "R7 abort masks start", int'(busy_o), 0);
  endtask

  task automatic t_start_busy;
    int n;
    vin = 777; settle_i = 8'd3; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    n = 1;
    repeat (6) begin @(negedge clk); n++; end
    start_i = 1'b1; settle_i = 8'd9;  // R8 stray start with new settle
    @(negedge clk); n++;
    start_i = 1'b0;
    while (!done_o && n < 5000) begin @(negedge clk); n++; end
    check(n == W * 4 + 1, "R8 timing kept", n, W * 4 + 1);
    check(int'(result_o) == 777, "R8 result kept", int'(result_o), 777);
    @(negedge clk);
  endtask

  task automatic t_abort_restart;
    vin = 100; settle_i = 8'd1; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (9) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    run_conv(613, 2);  // R9 fresh conversion after abort
    check(int'(result_o) == 613, "R9 restart code", int'(result_o), 613);
  endtask

  initial begin
    t_reset;
    t_codes;
    t_range_limits;
    t_abort;
    t_start_busy;
    t_abort_restart;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule